// File: doc/BRIEF.md
# Memory-to-Memory Copy Channel

This block is a single copy engine that moves a run of bytes from one place in memory to another. Software sets it up through a 32-bit register port. It writes a 64-bit source address and a 64-bit destination address, each as a low word and a high word, and a byte count. It then writes 1 to the run bit. The engine alternates one read beat and one write beat on a simple request/ready memory port until the count is used up. It then drops the run bit and raises a completion flag. The flag reaches the interrupt line only when the interrupt enable bit is set.

Three controls force the engine back to idle. A warm reset stops the copy in progress and leaves the programmed values in place. A hard reset returns every register to its default. A flush stops the copy in progress. Each control stays asserted until software writes it back to 0, and while any of them is set the engine cannot start.

Memory port convention: `memAddr` is a byte address. A read returns the four bytes at `memAddr`..`memAddr+3` on lanes 0..3 of `memRdata`. On a write, byte lane i of `memWdata` goes to `memAddr+i` when `memBe[i]` is 1. A beat completes in a cycle where both `memReq` and `memReady` are high.

Top module: `copy_dma_channel`

## Requirements
- R1: After reset, every register reads 0, `irqOut` is 0 and `memReq` is 0.
- R2: Writing 1 to bit 0 at offset 0x08 while the engine is idle, the length is nonzero and no stop control is set starts a copy. Bit 0 of 0x08 reads 1 while the copy runs. It reads 0 from the cycle after the last write beat, and in that same cycle bit 0 at offset 0x00 (completion flag) becomes 1.
- R3: A copy of length N makes the N bytes at the destination equal to the N source bytes, for any alignment of either address. Bytes outside the destination range are not changed. While 4 or more bytes remain, each write beat carries 4 bytes with `memBe`=4'b1111. The last N mod 4 bytes go as single-byte beats with `memBe`=4'b0001.
- R4: Starting with length 0 sets the completion flag on the same clock edge, leaves bit 0 of 0x08 at 0 and makes no memory request.
- R5: Writing 0 to bit 0 at 0x00 clears the completion flag. Writing 1 there leaves the flag unchanged.
- R6: `irqOut` is high exactly when the completion flag and bit 0 at offset 0x04 (interrupt enable) are both 1.
- R7: While bit 0 of 0x08 reads 1, writes to the source, destination and length registers are ignored, and the copy in progress uses the values it started with.
- R8: Setting bit 0 at offset 0x0C (warm reset) stops a running copy: the run bit reads 0 two cycles after the write, and the completion flag is not set. The programmed registers keep their values. Once the bit is cleared, a new copy runs normally.
- R9: While bit 1 at offset 0x0C (hard reset) is 1, every register except 0x0C itself reads 0 and the run bit reads 0. The bit reads back as written until software clears it.
- R10: Setting bit 0 at offset 0x14 (flush) stops a running copy without setting the completion flag. While the flush bit is 1, a start request is ignored and no memory request is made.
- R11: Offsets 0x1C and 0x20 hold address bits 31:0, and offsets 0x60 and 0x64 hold bits 63:32, of the source and destination. `memAddr` carries all 64 bits.
- R12: Offset 0x24 keeps only bits 27:0 (bits 31:28 read 0). Offset 0x28 is a 32-bit register that reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` (combinational) |
| irqOut | output | 1 | Completion interrupt |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | 64 | Byte address of the beat |
| memBe | output | 4 | Byte enables of a write beat |
| memWdata | output | 32 | Write data |
| memReady | input | 1 | Memory accepts the beat this cycle |
| memRdata | input | 32 | Read data, valid with `memReady` on a read beat |

## Verification
The bench compares the destination bytes after each copy, so a remaining-count or address-step error shows up there. Such an error can also show as a wrong count of word beats or byte beats, visible as soon as the copy ends. A state machine stuck busy, or one that goes idle early, is seen through the run bit within a few cycles of the expected end. An abort that sets the completion flag, or a stop control that does not stop the engine, shows on the flag or the run bit two cycles after the control write. A wrong high address word is caught on the first memory beat.

// File: rtl/copy_dma_pkg.sv
package copy_dma_pkg;
  localparam logic [7:0] OFS_FLAG    = 8'h00;
  localparam logic [7:0] OFS_IRQEN   = 8'h04;
  localparam logic [7:0] OFS_RUN     = 8'h08;
  localparam logic [7:0] OFS_RST     = 8'h0C;
  localparam logic [7:0] OFS_FLUSH   = 8'h14;
  localparam logic [7:0] OFS_SRC_LO  = 8'h1C;
  localparam logic [7:0] OFS_DST_LO  = 8'h20;
  localparam logic [7:0] OFS_LEN     = 8'h24;
  localparam logic [7:0] OFS_LEN_AUX = 8'h28;
  localparam logic [7:0] OFS_SRC_HI  = 8'h60;
  localparam logic [7:0] OFS_DST_HI  = 8'h64;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} copyState_t;

  typedef struct packed {
    logic load;     // latch programmed src/dst/len into the working counters
    logic capture;  // read beat accepted: hold read data
    logic advance;  // write beat accepted: step pointers and count
    logic wrPhase;  // address mux selects destination
  } copyStrobes_t;
endpackage

// File: rtl/copy_dma_datapath.sv
module copy_dma_datapath
  import copy_dma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  copyStrobes_t      strb,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  output logic              lastBeat
);
  logic [ADDR_W-1:0] curSrc, curDst;
  logic [LEN_W-1:0]  remain;
  logic [31:0]       dataBuf;
  logic              wordMode;
  logic [2:0]        stepSize;

  assign wordMode = remain >= LEN_W'(4);
  assign stepSize = wordMode ? 3'd4 : 3'd1;
  assign lastBeat = remain == LEN_W'(stepSize);
  assign memAddr  = strb.wrPhase ? curDst : curSrc;
  assign memWdata = dataBuf;
  assign memBe    = wordMode ? 4'b1111 : 4'b0001;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrc  <= '0;
      curDst  <= '0;
      remain  <= '0;
      dataBuf <= '0;
    end else begin
      if (strb.load) begin
        curSrc <= srcAddr;
        curDst <= dstAddr;
        remain <= xferLen;
      end else if (strb.advance) begin
        curSrc <= curSrc + ADDR_W'(stepSize);
        curDst <= curDst + ADDR_W'(stepSize);
        remain <= remain - LEN_W'(stepSize);
      end
      if (strb.capture) dataBuf <= memRdata;
    end
  end

  // R3
  remain_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> remain <= $past(remain));
endmodule

// File: rtl/copy_dma_ctrl.sv
module copy_dma_ctrl
  import copy_dma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irqOut,
  output logic              memReq,
  output logic              memWe,
  input  logic              memReady,
  input  logic              lastBeat,
  output copyStrobes_t      strb,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [LEN_W-1:0]  xferLen
);
  localparam int HI_W = ADDR_W - 32;

  copyState_t        state;
  logic              intFlag, intEn, warmRst, hardRst, flushBit;
  logic [31:0]       srcLo, dstLo, lenAux;
  logic [HI_W-1:0]   srcHi, dstHi;
  logic [LEN_W-1:0]  lenReg;
  logic              busy, holdOff, startReq, zeroDone, doneBeat, readAcc, writeAcc, cfgOpen;

  assign busy     = state != ST_IDLE;
  assign holdOff  = warmRst | hardRst | flushBit;
  assign startReq = regWe && regAddr == OFS_RUN && regWdata[0] && !busy && !holdOff;
  assign zeroDone = startReq && lenReg == '0;
  assign readAcc  = state == ST_READ && memReady && !holdOff;
  assign writeAcc = state == ST_WRITE && memReady && !holdOff;
  assign doneBeat = writeAcc && lastBeat;
  assign cfgOpen  = regWe && !busy && !hardRst;

  assign strb.load    = startReq && lenReg != '0;
  assign strb.capture = readAcc;
  assign strb.advance = writeAcc;
  assign strb.wrPhase = state == ST_WRITE;

  assign memReq  = busy && !holdOff;
  assign memWe   = state == ST_WRITE;
  assign irqOut  = intFlag & intEn;
  assign srcAddr = {srcHi, srcLo};
  assign dstAddr = {dstHi, dstLo};
  assign xferLen = lenReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (holdOff) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (strb.load) state <= ST_READ;
        ST_READ:  if (readAcc) state <= ST_WRITE;
        ST_WRITE: if (doneBeat) state <= ST_IDLE;
                  else if (writeAcc) state <= ST_READ;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {intFlag, intEn, warmRst, hardRst, flushBit} <= '0;
      {srcLo, dstLo, lenAux, srcHi, dstHi, lenReg} <= '0;
    end else begin
      if (regWe && regAddr == OFS_RST) {hardRst, warmRst} <= regWdata[1:0];
      if (hardRst) begin
        {intFlag, intEn, flushBit} <= '0;
        {srcLo, dstLo, lenAux, srcHi, dstHi, lenReg} <= '0;
      end else begin
        if (doneBeat || zeroDone) intFlag <= 1'b1;
        else if (regWe && regAddr == OFS_FLAG && !regWdata[0]) intFlag <= 1'b0;
        if (regWe && regAddr == OFS_IRQEN) intEn <= regWdata[0];
        if (regWe && regAddr == OFS_FLUSH) flushBit <= regWdata[0];
        if (regWe && regAddr == OFS_LEN_AUX) lenAux <= regWdata;
        if (cfgOpen) begin
          unique case (regAddr)
            OFS_SRC_LO: srcLo  <= regWdata;
            OFS_DST_LO: dstLo  <= regWdata;
            OFS_SRC_HI: srcHi  <= regWdata[HI_W-1:0];
            OFS_DST_HI: dstHi  <= regWdata[HI_W-1:0];
            OFS_LEN:    lenReg <= regWdata[LEN_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFS_FLAG:    regRdata = 32'(intFlag);
      OFS_IRQEN:   regRdata = 32'(intEn);
      OFS_RUN:     regRdata = 32'(busy);
      OFS_RST:     regRdata = 32'({hardRst, warmRst});
      OFS_FLUSH:   regRdata = 32'(flushBit);
      OFS_SRC_LO:  regRdata = srcLo;
      OFS_DST_LO:  regRdata = dstLo;
      OFS_LEN:     regRdata = 32'(lenReg);
      OFS_LEN_AUX: regRdata = lenAux;
      OFS_SRC_HI:  regRdata = 32'(srcHi);
      OFS_DST_HI:  regRdata = 32'(dstHi);
      default:     regRdata = '0;
    endcase
  end

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneBeat |=> (!busy && intFlag));
  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroDone |=> (intFlag && !busy && !memReq));
  // R7
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe && regAddr == OFS_SRC_LO && !hardRst) |=> $stable(srcLo));
  // R8 R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && holdOff) |=> (!busy && !memReq));
  // R9
  hard_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    hardRst |=> (!intFlag && !intEn && srcLo == '0 && lenReg == '0 && !busy));
endmodule

// File: rtl/copy_dma_channel.sv
module copy_dma_channel
  import copy_dma_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irqOut,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic              memReady,
  input  logic [31:0]       memRdata
);
  copyStrobes_t      strb;
  logic [ADDR_W-1:0] srcAddr, dstAddr;
  logic [LEN_W-1:0]  xferLen;
  logic              lastBeat;

  copy_dma_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut), .memReq(memReq), .memWe(memWe),
    .memReady(memReady), .lastBeat(lastBeat), .strb(strb),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .xferLen(xferLen)
  );

  copy_dma_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .xferLen(xferLen), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memBe(memBe), .lastBeat(lastBeat)
  );
endmodule

// File: tb/tb_copy_dma_channel.sv
`timescale 1ns/1ps
module tb_copy_dma_channel;
  import copy_dma_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut, memReq, memWe, memReady;
  logic [63:0] memAddr;
  logic [3:0]  memBe;
  logic [31:0] memWdata, memRdata;

  always #10 clk = ~clk;

  copy_dma_channel dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata)
  );

  // memory model: 4 KiB, indexed by address bits 11:0
  logic [7:0]  mem [0:4095];
  logic        slowMode = 1'b0;
  logic        stallGate = 1'b0;
  logic [31:0] expSrcHi = '0, expDstHi = '0;
  int          reqCount = 0, wordBeats = 0, byteBeats = 0, badBe = 0, hiErr = 0;
  logic [11:0] a0, a1, a2, a3;

  assign a0 = memAddr[11:0];
  assign a1 = a0 + 12'd1;
  assign a2 = a0 + 12'd2;
  assign a3 = a0 + 12'd3;
  assign memRdata = {mem[a3], mem[a2], mem[a1], mem[a0]};
  assign memReady = memReq && (!slowMode || stallGate);

  always @(negedge clk) stallGate <= ~stallGate;

  always @(posedge clk) begin
    if (memReq) begin
      reqCount = reqCount + 1;
      if (memAddr[63:32] != (memWe ? expDstHi : expSrcHi)) hiErr = hiErr + 1;
    end
    if (memReq && memReady && memWe) begin
      if (memBe == 4'b1111) wordBeats = wordBeats + 1;
      else if (memBe == 4'b0001) byteBeats = byteBeats + 1;
      else badBe = badBe + 1;
      if (memBe[0]) mem[a0] = memWdata[7:0];
      if (memBe[1]) mem[a1] = memWdata[15:8];
      if (memBe[2]) mem[a2] = memWdata[23:16];
      if (memBe[3]) mem[a3] = memWdata[31:24];
    end
  end

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    for (int k = 0; k < 5000; k++) begin
      rd(OFS_RUN, d);
      if (!d[0]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'((i * 7) + (v * 13) + 1);
  endfunction

  // prepares memory, runs a copy, checks data, guards, beat counts and flag
  task automatic runCopy(input string req, input int v, input logic [11:0] src,
                         input logic [11:0] dst, input int len);
    logic [31:0] d;
    int bad;
    for (int i = 0; i < len; i++) mem[src + 12'(i)] = pat(v, i);
    for (int i = -1; i <= len; i++) mem[dst + 12'(i)] = 8'hA5;
    wr(OFS_SRC_LO, 32'(src));
    wr(OFS_DST_LO, 32'(dst));
    wr(OFS_LEN, 32'(len));
    wr(OFS_FLAG, 32'h0);
    wordBeats = 0; byteBeats = 0; badBe = 0; hiErr = 0;
    wr(OFS_RUN, 32'h1);
    waitIdle();
    bad = 0;
    for (int i = 0; i < len; i++) if (mem[dst + 12'(i)] !== pat(v, i)) bad++;
    chk({req, " data"}, 64'(bad), 64'd0);
    chk({req, " guard"}, {mem[dst - 12'd1], mem[dst + 12'(len)]}, 16'hA5A5);
    chk({req, " word beats"}, 64'(wordBeats), 64'(len / 4));
    chk({req, " byte beats"}, 64'(byteBeats + badBe * 100), 64'(len % 4));
    chk({req, " high addr R11"}, 64'(hiErr), 64'd0);
    rd(OFS_FLAG, d);
    chk({req, " done flag R2"}, 64'(d), 64'd1);
  endtask

  typedef struct packed { logic [11:0] src; logic [11:0] dst; logic [11:0] len; } vec_t;
  localparam vec_t VECS [5] = '{
    '{12'h100, 12'h800, 12'd16},
    '{12'h103, 12'h901, 12'd13},
    '{12'h205, 12'hA02, 12'd3},
    '{12'h300, 12'hB07, 12'd1},
    '{12'h010, 12'hC00, 12'd64}
  };

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int reqBefore;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    begin
      int nz = 0;
      logic [7:0] offs [11] = '{OFS_FLAG, OFS_IRQEN, OFS_RUN, OFS_RST, OFS_FLUSH,
        OFS_SRC_LO, OFS_DST_LO, OFS_LEN, OFS_LEN_AUX, OFS_SRC_HI, OFS_DST_HI};
      for (int i = 0; i < 11; i++) begin rd(offs[i], d); if (d != 0) nz++; end
      chk("R1 registers zero", 64'(nz), 64'd0);
      chk("R1 irq/req idle", {irqOut, memReq}, 2'b00);
    end

    // R3 R2 vector table
    for (int v = 0; v < 5; v++) begin
      slowMode = v[0];
      runCopy("R3", v, VECS[v].src, VECS[v].dst, int'(VECS[v].len));
    end
    slowMode = 1'b0;

    // R6 interrupt gating, R5 flag clear
    chk("R6 irq masked", 64'(irqOut), 64'd0);
    wr(OFS_IRQEN, 32'h1);
    chk("R6 irq enabled", 64'(irqOut), 64'd1);
    wr(OFS_FLAG, 32'h1);
    rd(OFS_FLAG, d);
    chk("R5 write 1 keeps flag", 64'(d), 64'd1);
    wr(OFS_FLAG, 32'h0);
    rd(OFS_FLAG, d);
    chk("R5 write 0 clears flag", 64'(d), 64'd0);
    chk("R6 irq low after clear", 64'(irqOut), 64'd0);

    // R4 zero length
    wr(OFS_LEN, 32'h0);
    reqBefore = reqCount;
    wr(OFS_RUN, 32'h1);
    rd(OFS_RUN, d);
    chk("R4 run bit stays 0", 64'(d), 64'd0);
    rd(OFS_FLAG, d);
    chk("R4 flag set", 64'(d), 64'd1);
    repeat (3) @(negedge clk);
    chk("R4 no memory access", 64'(reqCount - reqBefore), 64'd0);
    wr(OFS_FLAG, 32'h0);

    // R7 config locked while busy
    for (int i = 0; i < 200; i++) mem[12'h400 + 12'(i)] = pat(9, i);
    wr(OFS_SRC_LO, 32'h400); wr(OFS_DST_LO, 32'hD00); wr(OFS_LEN, 32'd200);
    wordBeats = 0;
    wr(OFS_RUN, 32'h1);
    wr(OFS_SRC_LO, 32'h555); wr(OFS_LEN, 32'd5); wr(OFS_DST_LO, 32'h111);
    rd(OFS_SRC_LO, d); chk("R7 src locked", 64'(d), 64'h400);
    rd(OFS_LEN, d);    chk("R7 len locked", 64'(d), 64'd200);
    rd(OFS_DST_LO, d); chk("R7 dst locked", 64'(d), 64'hD00);
    waitIdle();
    chk("R7 copy used original length", 64'(wordBeats), 64'd50);
    chk("R7 last byte copied", 64'(mem[12'hD00 + 12'd199]), 64'(pat(9, 199)));
    wr(OFS_FLAG, 32'h0);

    // R8 warm reset aborts
    wr(OFS_LEN, 32'd400);
    wr(OFS_RUN, 32'h1);
    repeat (5) @(negedge clk);
    wr(OFS_RST, 32'h1);
    @(negedge clk);
    rd(OFS_RUN, d);  chk("R8 run bit cleared", 64'(d), 64'd0);
    rd(OFS_FLAG, d); chk("R8 no flag on abort", 64'(d), 64'd0);
    rd(OFS_SRC_LO, d); chk("R8 registers kept", 64'(d), 64'h400);
    wr(OFS_RST, 32'h0);
    runCopy("R8 after warm", 11, 12'h600, 12'hE03, 7);

    // R10 flush
    wr(OFS_FLAG, 32'h0);
    wr(OFS_LEN, 32'd400);
    wr(OFS_RUN, 32'h1);
    repeat (4) @(negedge clk);
    wr(OFS_FLUSH, 32'h1);
    @(negedge clk);
    rd(OFS_RUN, d);  chk("R10 run bit cleared", 64'(d), 64'd0);
    rd(OFS_FLAG, d); chk("R10 no flag", 64'(d), 64'd0);
    reqBefore = reqCount;
    wr(OFS_RUN, 32'h1);
    repeat (3) @(negedge clk);
    rd(OFS_RUN, d);
    chk("R10 start ignored while flushing", {d[0], 31'(reqCount - reqBefore)}, 32'd0);
    wr(OFS_FLUSH, 32'h0);

    // R9 hard reset
    wr(OFS_IRQEN, 32'h1);
    wr(OFS_LEN_AUX, 32'hCAFE0001);
    wr(OFS_RUN, 32'h1);
    repeat (3) @(negedge clk);
    wr(OFS_RST, 32'h2);
    @(negedge clk);
    rd(OFS_RUN, d);    chk("R9 run bit 0", 64'(d), 64'd0);
    rd(OFS_SRC_LO, d); chk("R9 src cleared", 64'(d), 64'd0);
    rd(OFS_IRQEN, d);  chk("R9 irq enable cleared", 64'(d), 64'd0);
    rd(OFS_LEN_AUX, d); chk("R9 aux length cleared", 64'(d), 64'd0);
    rd(OFS_RST, d);    chk("R9 reset reads back", 64'(d), 64'd2);
    wr(OFS_RST, 32'h0);
    rd(OFS_RST, d);    chk("R9 reset cleared", 64'(d), 64'd0);

    // R12 length width and aux register
    wr(OFS_LEN, 32'hFFFF_FFFF);
    rd(OFS_LEN, d);     chk("R12 length 28 bits", 64'(d), 64'h0FFF_FFFF);
    wr(OFS_LEN_AUX, 32'h1234_5678);
    rd(OFS_LEN_AUX, d); chk("R12 aux readback", 64'(d), 64'h1234_5678);

    // R11 high address words
    expSrcHi = 32'h1234_5678; expDstHi = 32'h9ABC_DEF0;
    wr(OFS_SRC_HI, expSrcHi);
    wr(OFS_DST_HI, expDstHi);
    rd(OFS_DST_HI, d); chk("R11 high readback", 64'(d), 64'h9ABC_DEF0);
    runCopy("R11", 12, 12'h040, 12'h062, 9);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule